// File: doc/BRIEF.md
# Serial Register Port with Clock-Copy Freeze

This block is a serial slave port that gives a host access to a 64-byte register space. The host selects the block by pulling an active-low select line. It then clocks in one command byte: a direction flag followed by a seven-bit address. A burst of data bytes follows, in either direction, for as long as select stays low. An internal pointer steps forward after every data byte, so one command can reach any run of consecutive locations. The serial output is tri-stateable and is driven only while a read burst is shifting data out.

The register space itself sits outside the block, behind a simple port: an address, a one-cycle write strobe with its data, and a combinational read-data return. The lowest eight locations hold the user-visible copy of a time-of-day counter. While the pointer sits on one of them, the block raises a freeze output so that the counters do not copy fresh time into the registers being accessed. After it completes a write to one of those locations, it pulses a divider-reset output. The serial lines are oversampled in the system clock domain through two-flop synchronizers, and edges are detected on the synchronized samples. The serial clock must therefore stay high and low for several system clock periods.

Top module: `serreg_port`

## Requirements
- R1: Serial data is MSB first. Input bits are taken on the rising serial clock edge and output bits change after the falling edge, so a host works whether its clock idles low or idles high.
- R2: The first bit after select falls gives the direction (1 = write, 0 = read), and the next seven bits give the start address.
- R3: Bit 6 of the address is ignored: addresses 40h–7Fh reach the same 64 locations as 00h–3Fh.
- R4: The pointer advances by one after each complete data byte and wraps from 3Fh to 00h.
- R5: While select is high, the serial output enable is low. Raising select ends the transfer, and a byte that was only partly shifted in is not written.
- R6: The freeze output is high only while the block is selected, past the command byte, with the pointer in 00h–07h. It falls on deselect or when the pointer moves to 08h or above.
- R7: A completed write to any of locations 00h–07h produces a one-cycle divider-reset pulse. Writes to 08h–3Fh produce none.
- R8: A write to location 00h stores 00h, whatever value was sent.
- R9: After reset, no transfer is accepted until select has been seen falling. A select that is already low when reset is released is ignored.
- R10: In a read, the first data bit appears on the output (with the enable high) after the falling edge that follows the eighth command bit, before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host |
| ser_dout_oe | output | 1 | Output enable for ser_dout; low means high impedance |
| rf_addr | output | 6 | Register-space address (write address during a strobe, pointer otherwise) |
| rf_wr_en | output | 1 | One-cycle write strobe |
| rf_wr_data | output | 8 | Write data |
| rf_rd_data | input | 8 | Read data for rf_addr, combinational |
| freeze_copy | output | 1 | Holds off time copies into locations 00h–07h |
| div_reset | output | 1 | One-cycle pulse after a write to 00h–07h |

## Verification
The bench aims at the pointer wrap from 3Fh to 00h, at addresses with bit 6 set, and at bursts that cross from 07h to 08h. A design that fails to wrap would corrupt the read-back data. One that decodes bit 6 would read a location it never wrote, and one with a wrong freeze boundary would show freeze at the wrong byte. It also writes nonzero data to location 00h, which must come back as zero, and counts divider-reset pulses against the clock-range writes. It drops select in the middle of a byte, which must not cause a write. Finally, it holds select low through reset: a design that treats a low level as a start would accept the write that follows.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    // Transfer phase: command byte first, then data bytes until deselect.
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_t;
endpackage

// File: rtl/serreg_sync.sv
// serreg_sync: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency needed) and that every
// level is held for longer than STAGES+1 system clock periods.
module serreg_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one flop rank of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/serreg_shift.sv
// serreg_shift: serial bit engine. Shifts in on synchronized clock rises and
// reports each completed byte; shifts out on falls when read data is wanted.
// Assumes the serial clock high and low times each exceed a few system clocks.
module serreg_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              din_s,
    input  logic              start,
    input  logic              active,
    input  logic              tx_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val,
    output logic              dout,
    output logic              oe
);
    localparam int              BIT_W    = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic              sck_prev_q;
    logic              sck_rise;
    logic              sck_fall;
    logic [BIT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] in_sh_q;
    logic [DATA_W-1:0] out_sh_q;

    assign sck_rise = sck_s & ~sck_prev_q;
    assign sck_fall = ~sck_s & sck_prev_q;

    // Purpose: remember the previous serial clock sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev_q <= 1'b0;
        else        sck_prev_q <= sck_s;
    end

    // Purpose: receive shift register, bit counter and byte-complete pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            in_sh_q   <= '0;
            byte_done <= 1'b0;
            byte_val  <= '0;
        end else begin
            byte_done <= 1'b0;
            if (start) begin
                bit_cnt_q <= '0;
            end else if (active && sck_rise) begin
                in_sh_q   <= {in_sh_q[DATA_W-2:0], din_s};
                bit_cnt_q <= bit_cnt_q + BIT_W'(1);
                if (bit_cnt_q == LAST_BIT) begin
                    byte_done <= 1'b1;
                    byte_val  <= {in_sh_q[DATA_W-2:0], din_s};
                end
            end
        end
    end

    // Purpose: transmit shift register; loads a new byte at a byte boundary fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sh_q <= '0;
            dout     <= 1'b0;
            oe       <= 1'b0;
        end else if (!active) begin
            oe       <= 1'b0;
        end else if (sck_fall && tx_en) begin
            if (bit_cnt_q == '0) begin
                dout     <= load_data[DATA_W-1];
                out_sh_q <= {load_data[DATA_W-2:0], 1'b0};
                oe       <= 1'b1;
            end else begin
                dout     <= out_sh_q[DATA_W-1];
                out_sh_q <= {out_sh_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !oe); // R5
    AST_BYTE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R4
endmodule

// File: rtl/serreg_ctrl.sv
// serreg_ctrl: transfer sequencer. Tracks select, decodes the command byte,
// owns the address pointer, issues register writes, freeze and divider reset.
// Assumes byte_done pulses arrive only while the shift engine is active.
module serreg_ctrl
    import serreg_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 6,
    parameter int CLK_REGS    = 8,
    parameter int SUBSEC_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] byte_val,
    output logic              start,
    output logic              active,
    output logic              tx_en,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              freeze,
    output logic              div_reset
);
    localparam logic [ADDR_W-1:0] CLK_LIMIT = ADDR_W'(CLK_REGS);
    localparam logic [ADDR_W-1:0] SUBSEC    = ADDR_W'(SUBSEC_ADDR);

    logic              sel_prev_q;
    logic              active_q;
    phase_t            phase_q;
    logic              is_wr_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic              wr_en_q;
    logic [DATA_W-1:0] wr_data_q;
    logic              div_q;

    // Purpose: previous select sample; reset to "selected" so a held-low
    // select after reset never produces a start.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev_q <= 1'b0;
        else        sel_prev_q <= sel_s;
    end

    assign start = sel_prev_q & ~sel_s;

    // Purpose: select tracking, command decode, pointer and write issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            phase_q   <= PH_CMD;
            is_wr_q   <= 1'b0;
            ptr_q     <= '0;
            wr_addr_q <= '0;
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
            div_q     <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            div_q   <= 1'b0;
            if (sel_s) begin
                active_q <= 1'b0;
                phase_q  <= PH_CMD;
            end else if (start) begin
                active_q <= 1'b1;
                phase_q  <= PH_CMD;
            end else if (active_q && byte_done) begin
                if (phase_q == PH_CMD) begin
                    is_wr_q <= byte_val[DATA_W-1];
                    ptr_q   <= byte_val[ADDR_W-1:0];
                    phase_q <= PH_DATA;
                end else begin
                    if (is_wr_q) begin
                        wr_en_q   <= 1'b1;
                        wr_addr_q <= ptr_q;
                        wr_data_q <= (ptr_q == SUBSEC) ? '0 : byte_val;
                        div_q     <= (ptr_q < CLK_LIMIT);
                    end
                    ptr_q <= ptr_q + ADDR_W'(1);
                end
            end
        end
    end

    assign active     = active_q;
    assign tx_en      = (phase_q == PH_DATA) && !is_wr_q;
    assign rf_addr    = wr_en_q ? wr_addr_q : ptr_q;
    assign rf_wr_en   = wr_en_q;
    assign rf_wr_data = wr_data_q;
    assign div_reset  = div_q;
    assign freeze     = active_q && (phase_q == PH_DATA) && (ptr_q < CLK_LIMIT);

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !sel_s && !start && byte_done && phase_q == PH_DATA &&
         ptr_q == {ADDR_W{1'b1}}) |=> (ptr_q == '0)); // R4
    AST_FREEZE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !freeze); // R6
    AST_DIVRST_CLOCK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset |-> (rf_wr_en && rf_addr < CLK_LIMIT)); // R7
    AST_DIVRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        div_reset |=> !div_reset); // R7
    AST_SUBSEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_wr_en && rf_addr == SUBSEC) |-> (rf_wr_data == '0)); // R8
    AST_WR_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> $past(active_q)); // R9
endmodule

// File: rtl/serreg_port.sv
// serreg_port: top of the serial register port. Synchronizes the serial
// lines, runs the bit engine and the transfer sequencer.
// Assumes a combinational register file behind rf_addr/rf_rd_data.
module serreg_port #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 64,
    parameter int CLK_REGS    = 8,
    parameter int SUBSEC_ADDR = 0,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_sel_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_dout_oe,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_wr_en,
    output logic [DATA_W-1:0] rf_wr_data,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              freeze_copy,
    output logic              div_reset
);
    logic [2:0]        sync_v;
    logic              start;
    logic              active;
    logic              tx_en;
    logic              byte_done;
    logic [DATA_W-1:0] byte_val;

    serreg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b000)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_sel_n, ser_clk, ser_din}),
        .sync_out (sync_v)
    );

    serreg_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sync_v[1]),
        .din_s     (sync_v[0]),
        .start     (start),
        .active    (active),
        .tx_en     (tx_en),
        .load_data (rf_rd_data),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .dout      (ser_dout),
        .oe        (ser_dout_oe)
    );

    serreg_ctrl #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .CLK_REGS    (CLK_REGS),
        .SUBSEC_ADDR (SUBSEC_ADDR)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (sync_v[2]),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .start      (start),
        .active     (active),
        .tx_en      (tx_en),
        .rf_addr    (rf_addr),
        .rf_wr_en   (rf_wr_en),
        .rf_wr_data (rf_wr_data),
        .freeze     (freeze_copy),
        .div_reset  (div_reset)
    );
endmodule

// File: tb/serreg_port_bench.sv
module serreg_port_bench;
    localparam int HALF = 8;   // system clocks per serial half period
    localparam int NVEC = 8;
    // vector: idle level[19], address[18:12], length[11:8], seed[7:0]
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 7'h10, 4'd3, 8'hA5},
        {1'b1, 7'h3E, 4'd4, 8'h11},
        {1'b0, 7'h00, 4'd3, 8'h5A},
        {1'b1, 7'h45, 4'd2, 8'hC3},
        {1'b0, 7'h07, 4'd3, 8'h70},
        {1'b1, 7'h20, 4'd1, 8'hFF},
        {1'b0, 7'h7F, 4'd2, 8'h81},
        {1'b1, 7'h2A, 4'd5, 8'h3C}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_sel_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_dout;
    logic       ser_dout_oe;
    logic [5:0] rf_addr;
    logic       rf_wr_en;
    logic [7:0] rf_wr_data;
    logic [7:0] rf_rd_data;
    logic       freeze_copy;
    logic       div_reset;

    logic [7:0] mem [64];
    logic [7:0] exp_mem [64];
    int n_chk = 0, n_fail = 0, wr_cnt = 0, div_cnt = 0;
    logic oe_all;
    logic done = 1'b0;

    always #2 clk = ~clk;

    serreg_port u_serreg_port (
        .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
        .rf_addr(rf_addr), .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data),
        .rf_rd_data(rf_rd_data), .freeze_copy(freeze_copy), .div_reset(div_reset)
    );

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'(i * 3 + 1);
            exp_mem[i] = 8'(i * 3 + 1);
        end
    end

    always @(posedge clk) begin
        if (rf_wr_en) begin
            mem[rf_addr] <= rf_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (div_reset) div_cnt <= div_cnt + 1;
    end
    assign rf_rd_data = mem[rf_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            ser_clk = 1'b0;
            ser_din = tx[b];
            waitc(HALF);
            rx[b]  = ser_dout;
            oe_all = oe_all & ser_dout_oe;
            ser_clk = 1'b1;
            waitc(HALF);
        end
    endtask

    task automatic burst(input logic idle, input logic wr, input logic [6:0] addr7,
                         input int n, input logic [7:0] seed, input string tag);
        logic [7:0] rx;
        int div_before, exp_div;
        int a;
        div_before = div_cnt;
        exp_div = 0;
        a = int'(addr7[5:0]);
        ser_clk = idle;
        waitc(2);
        ser_sel_n = 1'b0;
        waitc(HALF);
        xfer({wr, addr7}, rx);
        for (int i = 0; i < n; i++) begin
            int p;
            p = (a + i) % 64;
            chk("R6 freeze", {31'd0, freeze_copy}, {31'd0, p < 8});
            oe_all = 1'b1;
            xfer(wr ? 8'(seed + 8'(i)) : 8'h00, rx);
            if (wr) begin
                exp_mem[p] = (p == 0) ? 8'h00 : 8'(seed + 8'(i));
                if (p < 8) exp_div++;
            end else begin
                chk(tag, {24'd0, rx}, {24'd0, exp_mem[p]});
                chk("R10 oe during read", {31'd0, oe_all}, 32'd1);
            end
        end
        chk("R6 freeze end", {31'd0, freeze_copy}, {31'd0, ((a + n) % 64) < 8});
        ser_clk = idle;
        waitc(HALF);
        ser_sel_n = 1'b1;
        waitc(HALF);
        chk("R5 oe deselected", {31'd0, ser_dout_oe}, 32'd0);
        chk("R6 freeze deselected", {31'd0, freeze_copy}, 32'd0);
        if (wr) chk("R7 divider pulses", div_cnt - div_before, exp_div);
    endtask

    initial begin
        logic [7:0] rx;
        int wr_before;
        // R9: select held low through reset and afterwards.
        ser_sel_n = 1'b0;
        waitc(5);
        rst_n = 1'b1;
        waitc(4);
        chk("R5 reset oe", {31'd0, ser_dout_oe}, 32'd0);
        chk("R6 reset freeze", {31'd0, freeze_copy}, 32'd0);
        chk("R7 reset div", {31'd0, div_reset}, 32'd0);
        xfer({1'b1, 7'h30}, rx);
        xfer(8'h99, rx);
        xfer(8'h98, rx);
        chk("R9 no write before select falls", wr_cnt, 0);
        chk("R9 no freeze before select falls", {31'd0, freeze_copy}, 32'd0);
        ser_clk = 1'b0;
        waitc(HALF);
        ser_sel_n = 1'b1;
        waitc(HALF);
        burst(1'b0, 1'b0, 7'h30, 2, 8'h00, "R9 readback");

        // Vector table: write burst, then read back with address bit 6 flipped.
        for (int v = 0; v < NVEC; v++) begin
            burst(VEC[v][19], 1'b1, VEC[v][18:12], int'(VEC[v][11:8]), VEC[v][7:0], "R2");
            burst(VEC[v][19], 1'b0, VEC[v][18:12] ^ 7'h40, int'(VEC[v][11:8]),
                  8'h00, "R1 R2 R3 R4 readback");
        end

        // R8: nonzero write to location 0 reads back zero.
        burst(1'b1, 1'b1, 7'h00, 1, 8'hEE, "R8");
        burst(1'b0, 1'b0, 7'h00, 1, 8'h00, "R8 subsecond readback");

        // R5: partial byte then deselect must not write.
        wr_before = wr_cnt;
        ser_clk = 1'b0;
        waitc(2);
        ser_sel_n = 1'b0;
        waitc(HALF);
        xfer({1'b1, 7'h12}, rx);
        for (int b = 0; b < 4; b++) begin
            ser_clk = 1'b0; ser_din = 1'b1; waitc(HALF);
            ser_clk = 1'b1; waitc(HALF);
        end
        ser_clk = 1'b0;
        waitc(HALF);
        ser_sel_n = 1'b1;
        waitc(HALF);
        chk("R5 partial byte not written", wr_cnt - wr_before, 0);
        burst(1'b0, 1'b0, 7'h12, 1, 8'h00, "R5 partial readback");

        // R4: long read across the wrap.
        burst(1'b1, 1'b0, 7'h3C, 8, 8'h00, "R4 wrap read");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=finished");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule